// File: doc/BRIEF.md
# Tone Cadence Timer Controller

This block switches one tone oscillator on and off in a repeating on/off pattern. Two 16-bit duration registers, counted in ticks of an 8 kHz strobe (125 µs per count), set how long the tone sounds and how long it stays silent. A single counter measures the on phase, returns to zero at the end of that phase, then measures the off phase, and the pattern repeats for as long as either timer enable is set. With both timer enables clear, an enabled oscillator sounds continuously.

Turn-off can be aligned to the waveform. With the zero-cross option set, the tone keeps sounding after the on time ends, until the sign of the oscillator sample next changes. Without it the tone is cut at the end of the on phase. The end of each phase raises its own sticky pending flag, cleared by writing a 1, and each flag has its own mask bit. The gated tone goes to the transmit path, the receive path, both, or neither, as a 2-bit select chooses. The sine itself is produced elsewhere: this block takes the sample and uses its sign bit.

Top module: `tone_cadence_ctrl`

## Requirements
- R1: After reset, `live`, `tx_out`, `rx_out`, `irq_pend` and `irq` are all zero.
- R2: While `osc_en` is 0 the tone is silent (`live` = 0, both outputs 0) one cycle later and after, and the phase counter is held at zero, so re-enabling starts a fresh on phase.
- R3: With `osc_en` = 1 and both `on_tmr_en` and `off_tmr_en` clear, `live` rises one cycle after enable and stays 1 whatever the ticks.
- R4: With either timer enable set, the on phase lasts `on_time` ticks (at least one), after which the tone stops at the clock edge of that tick when `zc_en` = 0.
- R5: The off phase lasts `off_time` ticks (at least one), after which `live` returns to 1 and a new on phase begins; the pattern repeats.
- R6: The end of an on phase sets `irq_pend[0]`; the end of an off phase sets `irq_pend[1]`. Pending bits stay set until cleared.
- R7: `irq` is 1 exactly when some pending bit has its mask bit `irq_en` set to 1; a masked pending bit leaves `irq` at 0.
- R8: A 1 in `irq_clr[i]` clears `irq_pend[i]` at the next edge; a 0 leaves it; a new phase-end event in the same cycle wins over the clear.
- R9: `route` bit 0 sends the gated tone to `tx_out` and bit 1 sends it to `rx_out` (00 none, 01 transmit, 10 receive, 11 both); an unselected or silent path outputs 0.
- R10: With `zc_en` = 1, at the end of the on phase the tone keeps sounding until the sample's sign bit differs from that of the previous cycle, and stops at that edge.
- R11: Clearing both timer enables during the off phase returns the tone to continuous sounding one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 8 kHz timing strobe |
| osc_en | input | 1 | Oscillator enable |
| on_tmr_en | input | 1 | On-phase timer enable |
| off_tmr_en | input | 1 | Off-phase timer enable |
| zc_en | input | 1 | Delay cutoff to the next zero crossing |
| route | input | 2 | Output path select, bit 0 transmit, bit 1 receive |
| on_time | input | 16 | On-phase length in ticks |
| off_time | input | 16 | Off-phase length in ticks |
| osc_sample | input | 16 | Signed sample from the oscillator |
| irq_en | input | 2 | Mask bits, bit 0 on-end, bit 1 off-end |
| irq_clr | input | 2 | Write-1-to-clear strobes for the pending bits |
| tx_out | output | 16 | Gated tone to the transmit path |
| rx_out | output | 16 | Gated tone to the receive path |
| live | output | 1 | Tone currently sounding |
| irq_pend | output | 2 | Pending bits, bit 0 on-end, bit 1 off-end |
| irq | output | 1 | Masked interrupt request |

## Verification
On every cycle the assertions check that a disabled oscillator is silent, that an unselected path carries zero, that a pending bit holds until cleared and drops after a clear with no tick, and that continuous sounding persists. The phase lengths counted in ticks, the zero-crossing drain, the return to continuous tone and the mask behaviour of the interrupt line only show up in the bench's directed scenarios, which count ticks and compare against values worked out from the requirements.

// File: rtl/tcad_pkg.sv
package tcad_pkg;

    parameter int TIMER_W  = 16;
    parameter int SAMPLE_W = 16;

    // bit positions inside the route select
    localparam int RT_TX = 0;
    localparam int RT_RX = 1;
    localparam int N_PATH = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ON   = 2'd1,
        PH_OFF  = 2'd2
    } phase_e;

    typedef struct packed {
        logic off_end;  // bit 1
        logic on_end;   // bit 0
    } evt_t;

    function automatic logic sign_flip(input logic now_s, input logic prev_s);
        return now_s ^ prev_s;
    endfunction

endpackage

// File: rtl/tcad_seq.sv
module tcad_seq
    import tcad_pkg::*;
#(
    parameter int TW = TIMER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          osc_en,
    input  logic          cad_on,
    input  logic          zc_en,
    input  logic          sign_now,
    input  logic [TW-1:0] on_time,
    input  logic [TW-1:0] off_time,
    output logic          live,
    output evt_t          evt
);

    localparam int CW = TW + 1;

    phase_e        phase;
    logic [TW-1:0] cnt;
    logic          drain;
    logic          prev_sign;
    logic [CW-1:0] cnt_nx;
    logic          zc_hit;

    assign cnt_nx = {1'b0, cnt} + CW'(1);
    assign zc_hit = sign_flip(sign_now, prev_sign);

    always_comb begin
        evt.on_end  = tick && cad_on && osc_en && (phase == PH_ON)
                      && (cnt_nx >= {1'b0, on_time});
        evt.off_end = tick && cad_on && osc_en && (phase == PH_OFF)
                      && (cnt_nx >= {1'b0, off_time});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            drain     <= 1'b0;
            prev_sign <= 1'b0;
        end else begin
            prev_sign <= sign_now;
            if (!osc_en) begin
                phase <= PH_IDLE;
                cnt   <= '0;
                drain <= 1'b0;
            end else if (!cad_on) begin
                phase <= PH_ON;
                cnt   <= '0;
                drain <= 1'b0;
            end else begin
                case (phase)
                    PH_IDLE: begin
                        phase <= PH_ON;
                        cnt   <= '0;
                    end
                    PH_ON: begin
                        if (evt.on_end) begin
                            phase <= PH_OFF;
                            cnt   <= '0;
                            drain <= zc_en;
                        end else if (tick) begin
                            cnt <= cnt_nx[TW-1:0];
                        end
                    end
                    PH_OFF: begin
                        if (evt.off_end) begin
                            phase <= PH_ON;
                            cnt   <= '0;
                            drain <= 1'b0;
                        end else begin
                            if (tick) cnt <= cnt_nx[TW-1:0];
                            if (zc_hit) drain <= 1'b0;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    assign live = (phase == PH_ON) || drain;

endmodule

// File: rtl/tcad_irq.sv
module tcad_irq
    import tcad_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  evt_t       evt,
    input  logic [1:0] irq_en,
    input  logic [1:0] irq_clr,
    output logic [1:0] pend,
    output logic       irq
);

    logic [1:0] set_v;
    assign set_v = {evt.off_end, evt.on_end};

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~irq_clr) | set_v;
    end

    assign irq = |(pend & irq_en);

endmodule

// File: rtl/tcad_route.sv
module tcad_route
    import tcad_pkg::*;
#(
    parameter int SW = SAMPLE_W
) (
    input  logic              live,
    input  logic [N_PATH-1:0] route,
    input  logic [SW-1:0]     sample,
    output logic [SW-1:0]     path_out [N_PATH]
);

    for (genvar p = 0; p < N_PATH; p++) begin : g_path
        assign path_out[p] = (live && route[p]) ? sample : '0;
    end

endmodule

// File: rtl/tone_cadence_ctrl.sv
module tone_cadence_ctrl
    import tcad_pkg::*;
#(
    parameter int TW = TIMER_W,
    parameter int SW = SAMPLE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          osc_en,
    input  logic          on_tmr_en,
    input  logic          off_tmr_en,
    input  logic          zc_en,
    input  logic [1:0]    route,
    input  logic [TW-1:0] on_time,
    input  logic [TW-1:0] off_time,
    input  logic [SW-1:0] osc_sample,
    input  logic [1:0]    irq_en,
    input  logic [1:0]    irq_clr,
    output logic [SW-1:0] tx_out,
    output logic [SW-1:0] rx_out,
    output logic          live,
    output logic [1:0]    irq_pend,
    output logic          irq
);

    evt_t          evt;
    logic [SW-1:0] paths [N_PATH];

    tcad_seq #(.TW(TW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .osc_en   (osc_en),
        .cad_on   (on_tmr_en | off_tmr_en),
        .zc_en    (zc_en),
        .sign_now (osc_sample[SW-1]),
        .on_time  (on_time),
        .off_time (off_time),
        .live     (live),
        .evt      (evt)
    );

    tcad_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .irq_en  (irq_en),
        .irq_clr (irq_clr),
        .pend    (irq_pend),
        .irq     (irq)
    );

    tcad_route #(.SW(SW)) u_route (
        .live     (live),
        .route    (route),
        .sample   (osc_sample),
        .path_out (paths)
    );

    assign tx_out = paths[RT_TX];
    assign rx_out = paths[RT_RX];

endmodule

// File: rtl/tcad_checker.sv
module tcad_checker #(
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          osc_en,
    input logic          on_tmr_en,
    input logic          off_tmr_en,
    input logic [1:0]    route,
    input logic [1:0]    irq_clr,
    input logic [SW-1:0] tx_out,
    input logic [SW-1:0] rx_out,
    input logic          live,
    input logic [1:0]    irq_pend
);

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !osc_en |=> !live); // R2

    AST_CONT_TONE: assert property (@(posedge clk) disable iff (rst)
        (osc_en && !on_tmr_en && !off_tmr_en && live) |=> live); // R3

    AST_TX_UNSEL_ZERO: assert property (@(posedge clk) disable iff (rst)
        !route[0] |-> tx_out == '0); // R9

    AST_RX_UNSEL_ZERO: assert property (@(posedge clk) disable iff (rst)
        !route[1] |-> rx_out == '0); // R9

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_pend[0] && !irq_clr[0]) |=> irq_pend[0]); // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (irq_clr[1] && !tick) |=> !irq_pend[1]); // R8

endmodule

bind tone_cadence_ctrl tcad_checker #(.SW(SW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .osc_en     (osc_en),
    .on_tmr_en  (on_tmr_en),
    .off_tmr_en (off_tmr_en),
    .route      (route),
    .irq_clr    (irq_clr),
    .tx_out     (tx_out),
    .rx_out     (rx_out),
    .live       (live),
    .irq_pend   (irq_pend)
);

// File: tb/tone_cadence_ctrl_tb.sv
`timescale 1ns/1ps
module tone_cadence_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick, osc_en, on_tmr_en, off_tmr_en, zc_en;
    logic [1:0]  route, irq_en, irq_clr, irq_pend;
    logic [15:0] on_time, off_time, osc_sample, tx_out, rx_out;
    logic        live, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tone_cadence_ctrl u_dut (
        .clk(clk), .rst(rst), .tick(tick), .osc_en(osc_en),
        .on_tmr_en(on_tmr_en), .off_tmr_en(off_tmr_en), .zc_en(zc_en),
        .route(route), .on_time(on_time), .off_time(off_time),
        .osc_sample(osc_sample), .irq_en(irq_en), .irq_clr(irq_clr),
        .tx_out(tx_out), .rx_out(rx_out), .live(live),
        .irq_pend(irq_pend), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; @(negedge clk);
            tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic restart();
        osc_en = 1'b0; cyc(1);
        osc_en = 1'b1; cyc(1);
    endtask

    task automatic t_reset();
        check("R1 live", live, 0);
        check("R1 tx", tx_out, 0);
        check("R1 rx", rx_out, 0);
        check("R1 pend", irq_pend, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_disabled();
        osc_en = 1'b0; route = 2'b11; osc_sample = 16'd100;
        do_tick(3);
        check("R2 live off", live, 0);
        check("R2 tx off", tx_out, 0);
    endtask

    task automatic t_continuous();
        osc_en = 1'b1; cyc(1);
        check("R3 live on", live, 1);
        check("R3 tx", tx_out, 16'd100);
        do_tick(10);
        check("R3 still live", live, 1);
    endtask

    task automatic t_cadence();
        on_time = 16'd3; off_time = 16'd2;
        on_tmr_en = 1'b1; off_tmr_en = 1'b1;
        do_tick(2);
        check("R4 on before end", live, 1);
        check("R6 no pend yet", irq_pend, 0);
        do_tick(1);
        check("R4 off after 3 ticks", live, 0);
        check("R4 tx silent", tx_out, 0);
        check("R6 on-end pend", irq_pend, 2'b01);
        do_tick(1);
        check("R5 still off", live, 0);
        do_tick(1);
        check("R5 on again", live, 1);
        check("R6 both pend", irq_pend, 2'b11);
        do_tick(3);
        check("R5 repeats off", live, 0);
    endtask

    task automatic t_irq();
        irq_en = 2'b00; cyc(1);
        check("R7 masked", irq, 0);
        irq_en = 2'b10; cyc(1);
        check("R7 unmasked", irq, 1);
        irq_clr = 2'b10; cyc(1); irq_clr = 2'b00;
        check("R8 cleared bit1", irq_pend, 2'b01);
        check("R7 irq drops", irq, 0);
        irq_clr = 2'b01; cyc(1); irq_clr = 2'b00;
        check("R8 cleared bit0", irq_pend, 2'b00);
    endtask

    task automatic t_route();
        on_tmr_en = 1'b0; off_tmr_en = 1'b0; cyc(1);
        osc_sample = 16'h1234;
        for (int r = 0; r < 4; r++) begin
            route = 2'(r); cyc(1);
            check("R9 tx", tx_out, r[0] ? 16'h1234 : 16'h0);
            check("R9 rx", rx_out, r[1] ? 16'h1234 : 16'h0);
        end
    endtask

    task automatic t_zero_cross();
        osc_sample = 16'd100; zc_en = 1'b1;
        on_time = 16'd3; off_time = 16'd20;
        on_tmr_en = 1'b1; restart();
        do_tick(3);
        check("R10 drain live", live, 1);
        check("R10 drain tx", tx_out, 16'd100);
        cyc(2);
        check("R10 waits for crossing", live, 1);
        osc_sample = 16'hFFCE; cyc(1);
        check("R10 stops at crossing", live, 0);
        check("R10 tx zero", tx_out, 0);
    endtask

    task automatic t_stop_cadence();
        zc_en = 1'b0; osc_sample = 16'd100;
        on_time = 16'd2; off_time = 16'd30;
        restart();
        do_tick(2);
        check("R11 in off phase", live, 0);
        on_tmr_en = 1'b0; off_tmr_en = 1'b0; cyc(1);
        check("R11 continuous again", live, 1);
        do_tick(3);
        check("R11 stays on", live, 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 0; osc_en = 0; on_tmr_en = 0; off_tmr_en = 0;
        zc_en = 0; route = 0; on_time = 0; off_time = 0; osc_sample = 0;
        irq_en = 0; irq_clr = 0;
        cyc(3);
        rst = 1'b0; cyc(1);
        t_reset();
        t_disabled();
        t_continuous();
        t_cadence();
        t_irq();
        t_route();
        t_zero_cross();
        t_stop_cadence();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule